// File: doc/BRIEF.md
# I2C Bus Condition Detector

This block listens to the two wires of an I2C bus and tells the rest of the chip when bus conditions happen. The raw clock and data lines first go through a two-stage synchronizer. A small glitch filter follows, and it accepts a new level only after that level has held for a set number of system clocks. The filtered levels are then compared with their values one clock earlier.

When data falls while the clock stays high, the block reports a START. When data rises while the clock stays high, it reports a STOP. A START that arrives while a transfer is still open is also reported as a repeated START. Data moves while the clock is low are normal bit traffic and are never reported.

The block keeps a busy flag, which opens on a START and closes only on a STOP. It gives a one-cycle strobe for each kind of event. Each event kind also has its own sticky interrupt flag. Software enables each flag separately and clears it with a one-cycle strobe.

Top module: `i2c_cond_detect`

## Requirements
- R1: While reset is held, and on the first cycle after it, the busy flag, all three strobes, all interrupt flags and the interrupt line are low.
- R2: If data falls while the clock is high, start_pulse is high for exactly one cycle. The busy flag rises on the same clock edge. Count the first clock edge after the raw change as edge 1: the strobe and busy update on edge FILT_LEN+3.
- R3: If data rises while the clock is high, stop_pulse is high for one cycle on the same edge numbering as R2, and the busy flag falls on that edge.
- R4: A START detected while the busy flag is already high pulses both rstart_pulse and start_pulse in the same cycle. The busy flag stays high through it.
- R5: A change of data while the clock is low produces no strobe. It also leaves the busy flag and the interrupt flags unchanged.
- R6: After synchronization, a level change that lasts fewer than FILT_LEN clocks is filtered out and produces no event.
- R7: After reset, no event is reported until both filtered lines have been high together at least once. So a data rise seen before that point is not taken as a STOP.
- R8: Each event sets its own sticky flag in the same cycle as its strobe. The flags are bit 0 for START, bit 1 for STOP and bit 2 for repeated START. A flag stays set until a one-cycle strobe on the matching bit of irq_clr clears it on the next clock edge. A strobe on a bit leaves the other bits unchanged.
- R9: irq is high exactly when some flag is set and its matching irq_en bit is high. irq_en has no effect on whether flags get set.
- R10: The busy flag changes only with a START strobe (it rises) or a STOP strobe (it falls). Ordinary data bits never change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_raw | input | 1 | Unsynchronized bus clock line |
| sda_raw | input | 1 | Unsynchronized bus data line |
| irq_en | input | 3 | Per-source interrupt enable (0 start, 1 stop, 2 repeated start) |
| irq_clr | input | 3 | Write-one-to-clear strobes for the sticky flags |
| start_pulse | output | 1 | One-cycle strobe for any START |
| stop_pulse | output | 1 | One-cycle strobe for a STOP |
| rstart_pulse | output | 1 | One-cycle strobe for a START while busy |
| bus_busy | output | 1 | High between a START and the next STOP |
| irq_flags | output | 3 | Sticky event flags |
| irq | output | 1 | OR of enabled flags |

## Verification
The strobes, the busy flag and the flags all depend on a raw line change. They come due on the FILT_LEN+3rd clock edge after that change: two synchronizer stages, FILT_LEN filter cycles, and the output register. The driver records the cycle number when it changes a line. It then queues the expected strobe set for that cycle number plus FILT_LEN+3. A monitor samples on every falling clock edge and compares its sample with the queue, so an early, late, missing or extra strobe counts as a mismatch. A clear strobe acts on the next edge, and irq follows the enables with no delay. Those two results are checked at the falling edge that follows the stimulus.

// File: rtl/i2c_cd_pkg.sv
package i2c_cd_pkg;
  localparam int SRC_START  = 0;
  localparam int SRC_STOP   = 1;
  localparam int SRC_RSTART = 2;
  localparam int NSRC       = 3;

  // Data falls while the clock holds high across both samples.
  function automatic logic is_start(input logic scl_prev, input logic sda_prev,
                                    input logic scl_now, input logic sda_now);
    return scl_prev & scl_now & sda_prev & ~sda_now;
  endfunction

  // Data rises while the clock holds high across both samples.
  function automatic logic is_stop(input logic scl_prev, input logic sda_prev,
                                   input logic scl_now, input logic sda_now);
    return scl_prev & scl_now & ~sda_prev & sda_now;
  endfunction

  // Data moves while the clock is low: ordinary bit traffic.
  function automatic logic is_data_move(input logic scl_now, input logic sda_prev,
                                        input logic sda_now);
    return ~scl_now & (sda_prev ^ sda_now);
  endfunction
endpackage

// File: rtl/i2c_cd_line_filt.sv
module i2c_cd_line_filt #(
  parameter int FILT_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level
);
  localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end
  end

  // A new level is taken only after FILT_LEN consecutive differing samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      cnt   <= '0;
    end else if (s2 == level) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      level <= s2;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_cd_cond.sv
module i2c_cd_cond
  import i2c_cd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_evt,
  output logic stop_evt,
  output logic rstart_evt,
  output logic data_edge,
  output logic armed,
  output logic start_p,
  output logic stop_p,
  output logic rstart_p,
  output logic busy
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b0;
      sda_d <= 1'b0;
      armed <= 1'b0;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
      armed <= armed | (scl_f & sda_f);
    end
  end

  assign start_evt  = armed & is_start(scl_d, sda_d, scl_f, sda_f);
  assign stop_evt   = armed & is_stop(scl_d, sda_d, scl_f, sda_f);
  assign rstart_evt = start_evt & busy;
  assign data_edge  = is_data_move(scl_f, sda_d, sda_f);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_p  <= 1'b0;
      stop_p   <= 1'b0;
      rstart_p <= 1'b0;
      busy     <= 1'b0;
    end else begin
      start_p  <= start_evt;
      stop_p   <= stop_evt;
      rstart_p <= rstart_evt;
      if (stop_evt)       busy <= 1'b0;
      else if (start_evt) busy <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_cd_irq.sv
module i2c_cd_irq #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set,
  input  logic [NSRC-1:0] clr,
  input  logic [NSRC-1:0] en,
  output logic [NSRC-1:0] flags,
  output logic            irq
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end

  assign irq = |(flags & en);
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_cd_pkg::*;
#(
  parameter int FILT_LEN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_raw,
  input  logic            sda_raw,
  input  logic [NSRC-1:0] irq_en,
  input  logic [NSRC-1:0] irq_clr,
  output logic            start_pulse,
  output logic            stop_pulse,
  output logic            rstart_pulse,
  output logic            bus_busy,
  output logic [NSRC-1:0] irq_flags,
  output logic            irq
);
  logic [1:0] raw_v, filt_v;
  logic start_evt, stop_evt, rstart_evt, data_edge, armed;
  logic [NSRC-1:0] ev_set;

  assign raw_v = {sda_raw, scl_raw};

  for (genvar i = 0; i < 2; i++) begin : g_line
    i2c_cd_line_filt #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(raw_v[i]), .level(filt_v[i])
    );
  end

  i2c_cd_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_f(filt_v[0]), .sda_f(filt_v[1]),
    .start_evt(start_evt), .stop_evt(stop_evt), .rstart_evt(rstart_evt),
    .data_edge(data_edge), .armed(armed),
    .start_p(start_pulse), .stop_p(stop_pulse), .rstart_p(rstart_pulse),
    .busy(bus_busy)
  );

  always_comb begin
    ev_set             = '0;
    ev_set[SRC_START]  = start_evt;
    ev_set[SRC_STOP]   = stop_evt;
    ev_set[SRC_RSTART] = rstart_evt;
  end

  i2c_cd_irq #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(irq_clr), .en(irq_en),
    .flags(irq_flags), .irq(irq)
  );
endmodule

// File: rtl/i2c_cond_detect_chk.sv
module i2c_cond_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_pulse,
  input logic       stop_pulse,
  input logic       rstart_pulse,
  input logic       bus_busy,
  input logic [2:0] irq_flags,
  input logic [2:0] irq_clr,
  input logic       armed,
  input logic       data_edge
);
  a_r2_start_opens_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> bus_busy);
  a_r3_stop_closes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> !bus_busy);
  a_r2_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, stop_pulse}));
  a_r4_rstart_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rstart_pulse |-> (start_pulse && $past(bus_busy)));
  a_r10_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> start_pulse);
  a_r10_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> stop_pulse);
  a_r5_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    data_edge |=> (!start_pulse && !stop_pulse));
  a_r7_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (!start_pulse && !stop_pulse));
  a_r8_start_flag: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> irq_flags[0]);
  a_r8_stop_flag: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> irq_flags[1]);
  a_r8_flag_fall_by_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_flags[2]) |-> $past(irq_clr[2]));
endmodule

bind i2c_cond_detect i2c_cond_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
  .rstart_pulse(rstart_pulse), .bus_busy(bus_busy), .irq_flags(irq_flags),
  .irq_clr(irq_clr), .armed(armed), .data_edge(data_edge)
);

// File: tb/i2c_cond_detect_tb.sv
module i2c_cond_detect_tb;
  localparam int FILT = 2;
  localparam int LAT  = FILT + 3;
  localparam int HOLD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_raw = 1'b1;
  logic sda_raw = 1'b0;
  logic [2:0] irq_en = 3'b000;
  logic [2:0] irq_clr = 3'b000;
  logic start_pulse, stop_pulse, rstart_pulse, bus_busy, irq;
  logic [2:0] irq_flags;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct { int due; logic [2:0] ev; } exp_t;
  exp_t q[$];

  logic m_scl = 1'b1, m_sda = 1'b0, m_busy = 1'b0, m_armed = 1'b0;
  logic [2:0] m_flags = 3'b000;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_cond_detect #(.FILT_LEN(FILT)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_raw), .sda_raw(sda_raw),
    .irq_en(irq_en), .irq_clr(irq_clr), .start_pulse(start_pulse),
    .stop_pulse(stop_pulse), .rstart_pulse(rstart_pulse), .bus_busy(bus_busy),
    .irq_flags(irq_flags), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Driver: change lines at a falling edge, queue what the bench expects.
  task automatic drive(input logic scl_v, input logic sda_v);
    logic [2:0] ev;
    ev = 3'b000;
    @(negedge clk);
    if (m_armed && m_scl && scl_v && (m_sda !== sda_v)) begin
      if (!sda_v) begin
        ev[0] = 1'b1;
        if (m_busy) ev[2] = 1'b1;
        m_busy = 1'b1;
      end else begin
        ev[1] = 1'b1;
        m_busy = 1'b0;
      end
    end
    m_scl = scl_v;
    m_sda = sda_v;
    scl_raw = scl_v;
    sda_raw = sda_v;
    if (ev != 3'b000) begin
      q.push_back('{due: cyc + LAT, ev: ev});
      m_flags = m_flags | ev;
    end
    if (scl_v && sda_v) m_armed = 1'b1;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    drive(1'b0, m_sda);
    drive(1'b0, b);
    drive(1'b1, b);
    drive(1'b0, b);
  endtask

  task automatic sda_glitch();
    @(negedge clk);
    sda_raw = ~m_sda;
    @(negedge clk);
    sda_raw = m_sda;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic clear(input logic [2:0] m);
    @(negedge clk);
    irq_clr = m;
    @(negedge clk);
    irq_clr = 3'b000;
    m_flags = m_flags & ~m;
  endtask

  // Monitor: compares strobes against the queue on every falling edge.
  always @(negedge clk) begin
    logic [2:0] obs_v, exp_v;
    if (rst_n && !finished) begin
      obs_v = {rstart_pulse, stop_pulse, start_pulse};
      exp_v = 3'b000;
      while (q.size() > 0 && q[0].due <= cyc) begin
        if (q[0].due < cyc) begin
          n_chk++;
          n_fail++;
          $display("FAIL R2/R3/R4 missed event: actual none expected %0b", q[0].ev);
        end else begin
          exp_v = exp_v | q[0].ev;
        end
        void'(q.pop_front());
      end
      if (obs_v != 3'b000 || exp_v != 3'b000) begin
        n_chk++;
        if (obs_v !== exp_v) begin
          n_fail++;
          $display("FAIL R2/R3/R4/R5/R6/R7 strobes {rs,sp,st}: actual %0b expected %0b (cycle %0d)",
                   obs_v, exp_v, cyc);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", bus_busy, 0);
    chk("R1 flags in reset", irq_flags, 0);
    chk("R1 strobes in reset", {rstart_pulse, stop_pulse, start_pulse}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", irq, 0);

    // R7: data rises with clock high before both lines were seen high.
    drive(1'b1, 1'b1);
    chk("R7 no stop before arming: flags", irq_flags, 0);
    chk("R7 busy", bus_busy, 0);

    irq_en = 3'b111;
    drive(1'b1, 1'b0);            // START
    chk("R2 busy after start", bus_busy, 1);
    chk("R8 start flag", irq_flags, m_flags);
    chk("R9 irq enabled", irq, 1);

    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    chk("R5 flags after data", irq_flags, m_flags);
    chk("R10 busy across data", bus_busy, 1);

    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b0);            // repeated START
    chk("R4 busy kept", bus_busy, 1);
    chk("R4 rstart flag", irq_flags, m_flags);

    sda_glitch();                 // would be a STOP if accepted
    chk("R6 busy after glitch", bus_busy, 1);
    chk("R6 flags after glitch", irq_flags, m_flags);

    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);            // STOP
    chk("R3 busy after stop", bus_busy, 0);
    chk("R8 all flags", irq_flags, 3'b111);

    @(negedge clk); irq_en = 3'b000;
    @(negedge clk); chk("R9 all masked", irq, 0);
    clear(3'b001);
    chk("R8 clear start only", irq_flags, m_flags);
    irq_en = 3'b001;
    @(negedge clk); chk("R9 enabled but cleared", irq, 0);
    irq_en = 3'b010;
    @(negedge clk); chk("R9 stop enabled", irq, 1);
    clear(3'b110);
    chk("R8 clear rest", irq_flags, 0);
    chk("R9 irq after clear", irq, 0);

    sda_glitch();                 // would be a START if accepted
    chk("R6 idle glitch busy", bus_busy, 0);
    chk("R6 idle glitch flags", irq_flags, 0);

    irq_en = 3'b000;
    drive(1'b1, 1'b0);            // START with all masked
    chk("R9 flag set while masked", irq_flags, m_flags);
    chk("R9 irq masked", irq, 0);
    put_bit(1'b0);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);            // STOP
    chk("R10 busy closes on stop", bus_busy, 0);
    chk("R8 flags after second frame", irq_flags, m_flags);
    repeat (LAT + 2) @(negedge clk);
    chk("R2 queue drained", q.size(), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule